// File: doc/BRIEF.md
# Two-Dimensional Tiled Address Translator

This block turns a window-relative pixel coordinate into a location in a tiled graphics memory. A request carries a window identifier and virtual X and Y pixel coordinates. The upper bits of X and Y select a square tile of 256 x 256 pixels. Those tile numbers, joined with the window identifier, index a small lookup table that returns the physical tile number. The position inside the tile does not pass through the table. The row within the tile and the 32-pixel word within that row go straight into the low-order bits of the physical word address, so each tile fills one contiguous physical region and the width of the window never enters the calculation.

The five lowest bits of X pick one pixel inside a 32-pixel word. They come out as a one-hot write mask and do not address a word. A host port loads table entries. The table has no valid flags, so every lookup returns whatever the addressed entry holds. Keeping entries resident is left to the controlling software.

Requests and responses use valid/ready handshakes, with one registered stage between them.

Top module: `tvat_translator`

## Requirements
- R1: After a synchronous active-low reset, `rsp_valid` is 0 and `req_ready` is 1, provided no table write is present.
- R2: `rsp_addr` is the table entry in bits [18:11], Y[7:0] in bits [10:3], and X[7:5] in bits [2:0].
- R3: The table entry used is selected by the index {window, Y[11:8], X[11:8]}. Entries that differ in any of these three fields are independent.
- R4: `rsp_mask` has exactly one bit set. That bit is at position X[4:0], where bit 0 is the leftmost pixel of the word.
- R5: A request accepted on a clock edge (`req_valid` and `req_ready` both 1) shows up with `rsp_valid` = 1 after that edge. `rsp_valid` clears after an edge where `rsp_ready` is 1 and no new request is accepted.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and `rsp_addr` and `rsp_mask` stay unchanged.
- R7: In any cycle where `tbl_wr_en` is 1, `req_ready` is 0, so a table write wins over a lookup. A lookup of the same index accepted in the next cycle returns the newly written value.
- R8: A later write to an entry replaces its earlier value. Entries that were not written keep their values.
- R9: With `rsp_ready` held at 1 and no table writes, one request is accepted and one response is delivered on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A lookup request is present |
| req_ready | output | 1 | The block takes the request on this edge |
| req_win | input | 4 | Window identifier |
| req_x | input | 12 | Virtual X pixel coordinate |
| req_y | input | 12 | Virtual Y pixel coordinate |
| rsp_valid | output | 1 | A translated result is present |
| rsp_ready | input | 1 | The consumer takes the result on this edge |
| rsp_addr | output | 19 | Physical word address |
| rsp_mask | output | 32 | One-hot pixel mask within the word |
| tbl_wr_en | input | 1 | Write one table entry |
| tbl_wr_win | input | 4 | Window field of the entry to write |
| tbl_wr_ty | input | 4 | Y tile field of the entry to write |
| tbl_wr_tx | input | 4 | X tile field of the entry to write |
| tbl_wr_tile | input | 8 | Physical tile number to store |

## Verification
The hardest case to reach is a table write and a lookup of the same entry arriving together while the output is also stalled. In that case the write must win, the request must wait, and the later response must carry the new tile number. The stimulus holds a request valid across a write to its own index, with `rsp_ready` low for some of those cycles. A behavioural model follows the table contents and the handshake on every cycle. A filled table and a stretch of random traffic with random backpressure then cover the many index and mask combinations.

// File: rtl/tvat_pkg.sv
// Package: default field widths shared by the translator modules.
// Assumes: the X coordinate is laid out as {tile, word, bit} and Y as {tile, word}.
package tvat_pkg;
    localparam int unsigned DEF_WIN_W   = 4;  // window identifier bits
    localparam int unsigned DEF_TILE_W  = 4;  // tile-number bits on each axis
    localparam int unsigned DEF_XWORD_W = 3;  // words per tile row, log2
    localparam int unsigned DEF_YWORD_W = 8;  // rows per tile, log2
    localparam int unsigned DEF_BIT_W   = 5;  // pixels per word, log2
    localparam int unsigned DEF_PTILE_W = 8;  // physical tile number bits
endpackage

// File: rtl/tvat_field_split.sv
// Splits a virtual coordinate into a table index, the in-tile word offset
// and the pixel bit displacement. Purely combinational.
// Assumes: X = {tile_x, word_x, bit}, Y = {tile_y, word_y}.
module tvat_field_split #(
    parameter int unsigned WIN_W   = 4,
    parameter int unsigned TILE_W  = 4,
    parameter int unsigned XWORD_W = 3,
    parameter int unsigned YWORD_W = 8,
    parameter int unsigned BIT_W   = 5,
    localparam int unsigned X_W    = TILE_W + XWORD_W + BIT_W,
    localparam int unsigned Y_W    = TILE_W + YWORD_W,
    localparam int unsigned IDX_W  = WIN_W + 2 * TILE_W,
    localparam int unsigned LOW_W  = YWORD_W + XWORD_W
) (
    input  logic [WIN_W-1:0] win,
    input  logic [X_W-1:0]   vx,
    input  logic [Y_W-1:0]   vy,
    output logic [IDX_W-1:0] idx,
    output logic [LOW_W-1:0] low,
    output logic [BIT_W-1:0] bitsel
);
    // Table index: window, then Y tile, then X tile.
    assign idx    = {win, vy[Y_W-1 -: TILE_W], vx[X_W-1 -: TILE_W]};
    // In-tile word offset: row within the tile above word within the row.
    assign low    = {vy[YWORD_W-1:0], vx[BIT_W +: XWORD_W]};
    // Pixel position inside the word.
    assign bitsel = vx[BIT_W-1:0];
endmodule

// File: rtl/tvat_tile_table.sv
// Translation table: a plain synchronous RAM with one write port and one
// registered read port. No valid bits, so no faults are raised.
// Assumes: the caller never reads and writes in the same cycle.
module tvat_tile_table #(
    parameter int unsigned IDX_W  = 12,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Store a host-supplied entry.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Capture the addressed entry when a lookup is accepted; hold otherwise.
    always_ff @(posedge clk) begin
        if (rd_en) rd_q <= mem[rd_idx];
    end

    assign rd_data = rd_q;

    // R7: the lookup side must be blocked whenever the host writes.
    p_no_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    // R6: without a new lookup, the read result does not move.
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/tvat_bit_mask.sv
// Decodes a pixel bit displacement into a one-hot mask, bit n for value n.
// Assumes: the mask width is 2**SEL_W.
module tvat_bit_mask #(
    parameter int unsigned SEL_W  = 5,
    localparam int unsigned MASK_W = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [MASK_W-1:0] mask
);
    // One comparator per mask position.
    for (genvar g = 0; g < MASK_W; g++) begin : g_dec
        assign mask[g] = (sel == SEL_W'(g));
    end
endmodule

// File: rtl/tvat_translator.sv
// Top: translates {window, X, Y} into a physical word address and pixel mask.
// One registered stage with valid/ready on both sides. Host writes to the
// table take priority, so a lookup waits during a write cycle.
// Assumes: table contents are managed externally; every lookup is served.
module tvat_translator
    import tvat_pkg::*;
#(
    parameter int unsigned WIN_W   = DEF_WIN_W,
    parameter int unsigned TILE_W  = DEF_TILE_W,
    parameter int unsigned XWORD_W = DEF_XWORD_W,
    parameter int unsigned YWORD_W = DEF_YWORD_W,
    parameter int unsigned BIT_W   = DEF_BIT_W,
    parameter int unsigned PTILE_W = DEF_PTILE_W,
    localparam int unsigned X_W    = TILE_W + XWORD_W + BIT_W,
    localparam int unsigned Y_W    = TILE_W + YWORD_W,
    localparam int unsigned IDX_W  = WIN_W + 2 * TILE_W,
    localparam int unsigned LOW_W  = YWORD_W + XWORD_W,
    localparam int unsigned ADDR_W = PTILE_W + LOW_W,
    localparam int unsigned MASK_W = 1 << BIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [WIN_W-1:0]   req_win,
    input  logic [X_W-1:0]     req_x,
    input  logic [Y_W-1:0]     req_y,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [ADDR_W-1:0]  rsp_addr,
    output logic [MASK_W-1:0]  rsp_mask,
    input  logic               tbl_wr_en,
    input  logic [WIN_W-1:0]   tbl_wr_win,
    input  logic [TILE_W-1:0]  tbl_wr_ty,
    input  logic [TILE_W-1:0]  tbl_wr_tx,
    input  logic [PTILE_W-1:0] tbl_wr_tile
);
    logic [IDX_W-1:0]   lk_idx;
    logic [LOW_W-1:0]   lk_low;
    logic [BIT_W-1:0]   lk_bit;
    logic [MASK_W-1:0]  lk_mask;
    logic [PTILE_W-1:0] tile_q;
    logic [LOW_W-1:0]   low_q;
    logic [MASK_W-1:0]  mask_q;
    logic               valid_q;
    logic               accept;
    logic               out_free;

    tvat_field_split #(
        .WIN_W(WIN_W), .TILE_W(TILE_W), .XWORD_W(XWORD_W),
        .YWORD_W(YWORD_W), .BIT_W(BIT_W)
    ) u_split (
        .win(req_win), .vx(req_x), .vy(req_y),
        .idx(lk_idx), .low(lk_low), .bitsel(lk_bit)
    );

    tvat_bit_mask #(.SEL_W(BIT_W)) u_mask (
        .sel(lk_bit), .mask(lk_mask)
    );

    tvat_tile_table #(.IDX_W(IDX_W), .DATA_W(PTILE_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr_en),
        .wr_idx({tbl_wr_win, tbl_wr_ty, tbl_wr_tx}),
        .wr_data(tbl_wr_tile),
        .rd_en(accept), .rd_idx(lk_idx), .rd_data(tile_q)
    );

    // Output stage can take a new result when empty or being drained.
    assign out_free  = !valid_q || rsp_ready;
    // Host writes win: lookups are refused in a write cycle.
    assign req_ready = out_free && !tbl_wr_en;
    assign accept    = req_valid && req_ready;

    // Output valid flag: set on accept, cleared when drained.
    always_ff @(posedge clk) begin
        if (!rst_n)          valid_q <= 1'b0;
        else if (accept)     valid_q <= 1'b1;
        else if (rsp_ready)  valid_q <= 1'b0;
    end

    // Pass-through fields registered alongside the table read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            mask_q <= '0;
        end else if (accept) begin
            low_q  <= lk_low;
            mask_q <= lk_mask;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_addr  = {tile_q, low_q};
    assign rsp_mask  = mask_q;

    // R4: a presented result always has a single pixel selected.
    p_mask_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones(rsp_mask) == 1);

    // R5: an accepted request is visible after the edge.
    p_accept_shows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R6: a stalled result keeps its value and blocks new requests.
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_mask));

    p_stall_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    // R7: no request is taken while the host writes.
    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> !req_ready);
endmodule

// File: tb/tvat_translator_test.sv
// Bench: behavioural reference model (shadow table plus one-slot output
// model) compared against the ports every cycle, just before each edge.
module tvat_translator_test;
    localparam int PERIOD = 10;
    localparam int TBL_N  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_win = '0;
    logic [11:0] req_x = '0;
    logic [11:0] req_y = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [18:0] rsp_addr;
    logic [31:0] rsp_mask;
    logic        tbl_wr_en = 1'b0;
    logic [3:0]  tbl_wr_win = '0;
    logic [3:0]  tbl_wr_ty = '0;
    logic [3:0]  tbl_wr_tx = '0;
    logic [7:0]  tbl_wr_tile = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit model_on = 0;
    string tag = "R2 R3";

    int shadow [TBL_N];
    bit m_valid = 0;
    int m_addr = 0;
    longint m_mask = 0;

    always #(PERIOD/2) clk = ~clk;

    tvat_translator uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_win(req_win), .req_x(req_x), .req_y(req_y),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_mask(rsp_mask),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_win(tbl_wr_win),
        .tbl_wr_ty(tbl_wr_ty), .tbl_wr_tx(tbl_wr_tx),
        .tbl_wr_tile(tbl_wr_tile)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare ports with the model, then advance the model across the edge.
    task automatic tick();
        int idx;
        bit exp_ready;
        bit acc;
        #(PERIOD/2 - 1);
        if (model_on) begin
            exp_ready = (!m_valid || rsp_ready) && !tbl_wr_en;
            chk(req_ready == exp_ready, "R6 R7 ready", req_ready, exp_ready);
            chk(rsp_valid == m_valid, "R5 valid", rsp_valid, m_valid);
            if (m_valid) begin
                chk(rsp_addr == 19'(m_addr), {tag, " addr"}, rsp_addr, m_addr);
                chk(rsp_mask == 32'(m_mask), "R4 mask", rsp_mask, m_mask);
            end
            acc = req_valid && exp_ready;
            if (tbl_wr_en)
                shadow[tbl_wr_win * 256 + tbl_wr_ty * 16 + tbl_wr_tx] = tbl_wr_tile;
            if (acc) begin
                idx = req_win * 256 + (req_y / 256) * 16 + (req_x / 256);
                m_valid = 1;
                m_addr = shadow[idx] * 2048 + (req_y % 256) * 8 + (req_x / 32) % 8;
                m_mask = longint'(1) << (req_x % 32);
            end else if (rsp_ready) begin
                m_valid = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hwrite(input int w, input int ty, input int tx, input int t);
        tbl_wr_en = 1; tbl_wr_win = 4'(w); tbl_wr_ty = 4'(ty); tbl_wr_tx = 4'(tx);
        tbl_wr_tile = 8'(t);
    endtask

    task automatic req(input int w, input int x, input int y);
        req_valid = 1; req_win = 4'(w); req_x = 12'(x); req_y = 12'(y);
    endtask

    task automatic idle();
        req_valid = 0; tbl_wr_en = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state at the ports.
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        @(negedge clk);
        model_on = 1;

        // Fill the whole table through the host port.
        for (int i = 0; i < TBL_N; i++) begin
            hwrite(i / 256, (i / 16) % 16, i % 16, (i * 37 + 11) % 256);
            tick();
        end
        idle();
        rsp_ready = 1;

        // R2 R3 R4 R9: back-to-back lookups across windows, tiles and bit ends.
        tag = "R2 R3 R9";
        req(0, 0, 0);                 tick();
        req(0, 12'hFFF, 12'hFFF);     tick();
        req(15, 12'h31F, 12'h5A7);    tick();
        req(7, 12'h100, 12'h000);     tick();
        req(7, 12'h000, 12'h100);     tick();
        req(8, 12'h0E1, 12'h0FF);     tick();
        idle(); tick(); tick();

        // R6: stalled output with a waiting request.
        tag = "R6";
        req(3, 12'h2A5, 12'h3C4); tick();
        rsp_ready = 0;
        req(4, 12'h777, 12'h888);
        repeat (4) tick();
        rsp_ready = 1; tick(); tick();
        idle(); tick();

        // R7: write and lookup of the same entry collide, partly under stall.
        tag = "R7";
        req(5, 12'hA40, 12'h6B0); tick();
        rsp_ready = 0;
        hwrite(5, 6, 10, 8'hC3);
        req(5, 12'hA5F, 12'h6EE);
        tick();
        rsp_ready = 1;
        hwrite(5, 6, 10, 8'h3C);
        tick();
        tbl_wr_en = 0; tick();
        idle(); tick(); tick();

        // R8: overwrite one entry, neighbours keep their values.
        tag = "R8";
        hwrite(2, 1, 1, 8'h55); tick();
        hwrite(2, 1, 1, 8'hAA); tick();
        tbl_wr_en = 0;
        req(2, 12'h11F, 12'h1FF); tick();
        req(2, 12'h21F, 12'h1FF); tick();
        req(2, 12'h11F, 12'h2FF); tick();
        req(3, 12'h11F, 12'h1FF); tick();
        idle(); tick(); tick();

        // Random traffic with random backpressure and occasional writes.
        tag = "R2 R3";
        for (int k = 0; k < 3000; k++) begin
            req_valid = 1'($urandom % 4 != 0);
            req_win = 4'($urandom); req_x = 12'($urandom); req_y = 12'($urandom);
            rsp_ready = 1'($urandom % 3 != 0);
            if ($urandom % 8 == 0) hwrite($urandom % 16, $urandom % 16, $urandom % 16, $urandom % 256);
            else tbl_wr_en = 0;
            tick();
        end
        idle(); rsp_ready = 1; tick(); tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule